// File: doc/BRIEF.md
# Deep Stop Power Sequencer

This block moves a small chip between normal operation and a deep stop state in which the core clocks, the PLL and both high-speed oscillators are switched off. A sleep request starts entry only when the deep-sleep enable is set. Entry is held back while a flash program operation or a peripheral bus transfer is still running. Two option inputs, captured at the moment of entry, choose whether the flash is powered down and whether the regulator drops to its low-power mode while stopped. Internal memory and registers keep their contents; this block only drives enables.

A wakeup event brings the regulator back to normal mode and the flash out of power-down. The sequencer then waits for the oscillator-ready handshake and, when the flash was powered down, for a minimum settle count and the flash-ready handshake. Only after that does it release the core clock. After wakeup the system always runs from the internal high-speed oscillator. A wakeup that arrives while entry is still held back cancels the entry, and the core clock is never gated. A low-speed watchdog enable, once started, stays on through stop until reset.

Top module: `stop_seq_ctrl`

## Requirements
- R1: After synchronous reset: `state_o`=0 (run), `core_clk_en_o`=1, `hsi_en_o`=1, `fast_src_en_o`=0, `clk_sel_int_o`=1, `flash_pd_o`=0, `reg_lp_o`=0, `lsi_en_o`=0.
- R2: In run (state 0), `sleep_req_i` with `deep_en_i`=1 moves the state to 1 (waiting for idle) one cycle later. `sleep_req_i` with `deep_en_i`=0 has no effect.
- R3: In state 1, while `flash_busy_i` or `bus_busy_i` is high, the state stays at 1. In the cycle after both are low, the state is 2 (enter).
- R4: In state 2, `core_clk_en_o`=0 while the oscillators stay on. The next cycle is state 3 (stopped), in which `core_clk_en_o`, `hsi_en_o` and `fast_src_en_o` are all 0.
- R5: `flash_pd_en_i` is sampled on the step from state 1 to state 2. `flash_pd_o` is 1 only in state 3 and only when that sample was 1.
- R6: `lp_reg_en_i` is sampled on the same step. `reg_lp_o` is 1 only in state 3 and only when that sample was 1.
- R7: `wake_i` in state 1 returns the state to 0 the next cycle, even if both busy inputs are low. `core_clk_en_o` stays 1 throughout.
- R8: `wake_i` in state 3 gives state 4 (waking) the next cycle, with `reg_lp_o`=0, `flash_pd_o`=0, `hsi_en_o`=1 and `core_clk_en_o`=0.
- R9: State 4 is left for state 0 only when `osc_ready_i` is 1. When flash was powered down, state 4 also lasts at least FLASH_WAKE_CYCLES cycles (default 16) and requires `flash_ready_i`=1. Otherwise a single cycle is enough.
- R10: `sel_ext_req_i` in state 0 sets `clk_sel_int_o`=0 and `fast_src_en_o`=1 the next cycle. On return from stop, `clk_sel_int_o`=1 and `fast_src_en_o`=0.
- R11: Once `wdg_start_i` has been high, `lsi_en_o` is 1 from the next cycle on, in every state, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Core asks to sleep |
| deep_en_i | input | 1 | Sleep request means deep stop |
| flash_pd_en_i | input | 1 | Option: power down flash while stopped |
| lp_reg_en_i | input | 1 | Option: low-power regulator while stopped |
| flash_busy_i | input | 1 | Flash program operation in flight |
| bus_busy_i | input | 1 | Peripheral bus transfer in flight |
| wake_i | input | 1 | Wakeup event |
| osc_ready_i | input | 1 | Internal high-speed oscillator stable |
| flash_ready_i | input | 1 | Flash out of power-down |
| sel_ext_req_i | input | 1 | Switch system clock to PLL/external source |
| wdg_start_i | input | 1 | Low-speed watchdog started |
| state_o | output | 3 | 0 run, 1 wait idle, 2 enter, 3 stopped, 4 waking |
| core_clk_en_o | output | 1 | Core-domain clock enable |
| hsi_en_o | output | 1 | Internal high-speed oscillator enable |
| fast_src_en_o | output | 1 | PLL and external oscillator enable |
| clk_sel_int_o | output | 1 | 1 = system clock from internal oscillator |
| flash_pd_o | output | 1 | Flash power-down |
| reg_lp_o | output | 1 | Regulator low-power mode |
| lsi_en_o | output | 1 | Low-speed oscillator kept on for watchdog |

## Verification
A wrong state register shows on `state_o` and the clock enables in the very cycle it occurs. Every output is registered from the next-state decode, so no delay stage hides the error. A stale option latch shows only when stop is reached, as a wrong `flash_pd_o` or `reg_lp_o` in state 3. A wrong settle counter shows at the end of waking, as a `state_o` of 0 that arrives too early or too late. The bench therefore compares every output in every cycle against a cycle-level model and also measures the length of the waking phase directly.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ENTER = 3'd2,
    ST_STOP  = 3'd3,
    ST_WAKE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/stop_idle_gate.sv
module stop_idle_gate #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] busy_i,
  output logic               idle_o
);
  // Entry may proceed only when no activity source is in flight.
  assign idle_o = ~|busy_i;
endmodule

// File: rtl/stop_wake_timer.sv
module stop_wake_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R9: a fresh load always starts a non-trivial window when CYCLES > 1
  a_r9_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    (load_i && CYCLES > 1) |=> !zero_o);
endmodule

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
  import stop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req_i,
  input  logic       deep_en_i,
  input  logic       idle_i,
  input  logic       wake_i,
  input  logic       osc_ready_i,
  input  logic       flash_ready_i,
  input  logic       timer_zero_i,
  input  logic       fpd_cfg_i,
  input  logic       lp_cfg_i,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       fpd_d,
  output logic       lp_d,
  output logic       timer_load_o,
  output logic       timer_run_o
);
  logic fpd_q, lp_q;
  logic wake_done;

  assign wake_done = osc_ready_i && (!fpd_q || (timer_zero_i && flash_ready_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (sleep_req_i && deep_en_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (wake_i)      state_d = ST_RUN;
        else if (idle_i) state_d = ST_ENTER;
      end
      ST_ENTER: state_d = ST_STOP;
      ST_STOP:  if (wake_i) state_d = ST_WAKE;
      ST_WAKE:  if (wake_done) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  // Options are captured on the step into ENTER and held through stop.
  always_comb begin
    fpd_d = fpd_q;
    lp_d  = lp_q;
    if (state_q == ST_WAIT && state_d == ST_ENTER) begin
      fpd_d = fpd_cfg_i;
      lp_d  = lp_cfg_i;
    end
  end

  assign timer_load_o = (state_q == ST_STOP) && wake_i;
  assign timer_run_o  = (state_q == ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      fpd_q   <= 1'b0;
      lp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fpd_q   <= fpd_d;
      lp_q    <= lp_d;
    end
  end

  // R3: no entry while an access is in flight
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !wake_i && !idle_i) |=> state_q == ST_WAIT);
  // R7: wakeup during wait cancels entry
  a_r7_cancel: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && wake_i) |=> state_q == ST_RUN);
  // R9: waking needs the oscillator ready
  a_r9_osc_wait: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE && !osc_ready_i) |=> state_q == ST_WAKE);
  // R4: enter always proceeds to stop
  a_r4_enter_step: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENTER) |=> state_q == ST_STOP);
endmodule

// File: rtl/stop_seq_outreg.sv
module stop_seq_outreg
  import stop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d,
  input  logic       fpd_d,
  input  logic       lp_d,
  input  logic       ext_d,
  input  logic       wdg_d,
  output logic [2:0] state_o,
  output logic       core_clk_en_o,
  output logic       hsi_en_o,
  output logic       fast_src_en_o,
  output logic       clk_sel_int_o,
  output logic       flash_pd_o,
  output logic       reg_lp_o,
  output logic       lsi_en_o
);
  logic running, stopped, fast_ok;

  assign running = (state_d == ST_RUN) || (state_d == ST_WAIT);
  assign stopped = (state_d == ST_STOP);
  assign fast_ok = running || (state_d == ST_ENTER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o       <= 3'(ST_RUN);
      core_clk_en_o <= 1'b1;
      hsi_en_o      <= 1'b1;
      fast_src_en_o <= 1'b0;
      clk_sel_int_o <= 1'b1;
      flash_pd_o    <= 1'b0;
      reg_lp_o      <= 1'b0;
      lsi_en_o      <= 1'b0;
    end else begin
      state_o       <= 3'(state_d);
      core_clk_en_o <= running;
      hsi_en_o      <= !stopped;
      fast_src_en_o <= ext_d && fast_ok;
      clk_sel_int_o <= !ext_d;
      flash_pd_o    <= stopped && fpd_d;
      reg_lp_o      <= stopped && lp_d;
      lsi_en_o      <= wdg_d;
    end
  end

  // R4: nothing high-speed runs in stop
  a_r4_stop_off: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'(ST_STOP)) |-> (!core_clk_en_o && !hsi_en_o && !fast_src_en_o));
  // R8: regulator and flash are back up while waking
  a_r8_wake_up: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'(ST_WAKE)) |-> (!reg_lp_o && !flash_pd_o && hsi_en_o && !core_clk_en_o));
  // R11: low-speed enable is sticky
  a_r11_lsi_sticky: assert property (@(posedge clk) disable iff (rst)
    lsi_en_o |=> lsi_en_o);
endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
  import stop_seq_pkg::*;
#(
  parameter int FLASH_WAKE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req_i,
  input  logic       deep_en_i,
  input  logic       flash_pd_en_i,
  input  logic       lp_reg_en_i,
  input  logic       flash_busy_i,
  input  logic       bus_busy_i,
  input  logic       wake_i,
  input  logic       osc_ready_i,
  input  logic       flash_ready_i,
  input  logic       sel_ext_req_i,
  input  logic       wdg_start_i,
  output logic [2:0] state_o,
  output logic       core_clk_en_o,
  output logic       hsi_en_o,
  output logic       fast_src_en_o,
  output logic       clk_sel_int_o,
  output logic       flash_pd_o,
  output logic       reg_lp_o,
  output logic       lsi_en_o
);
  localparam int NUM_BUSY = 2;

  seq_state_e state_q, state_d;
  logic idle, fpd_d, lp_d, t_load, t_run, t_zero;
  logic ext_q, ext_d, wdg_q, wdg_d;

  stop_idle_gate #(.NUM_SRC(NUM_BUSY)) idle_i (
    .busy_i ({bus_busy_i, flash_busy_i}),
    .idle_o (idle)
  );

  stop_wake_timer #(.CYCLES(FLASH_WAKE_CYCLES)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (t_load),
    .run_i  (t_run),
    .zero_o (t_zero)
  );

  stop_seq_fsm fsm_i (
    .clk           (clk),
    .rst           (rst),
    .sleep_req_i   (sleep_req_i),
    .deep_en_i     (deep_en_i),
    .idle_i        (idle),
    .wake_i        (wake_i),
    .osc_ready_i   (osc_ready_i),
    .flash_ready_i (flash_ready_i),
    .timer_zero_i  (t_zero),
    .fpd_cfg_i     (flash_pd_en_i),
    .lp_cfg_i      (lp_reg_en_i),
    .state_q       (state_q),
    .state_d       (state_d),
    .fpd_d         (fpd_d),
    .lp_d          (lp_d),
    .timer_load_o  (t_load),
    .timer_run_o   (t_run)
  );

  // Clock source: leaving for stop always falls back to the internal oscillator.
  always_comb begin
    ext_d = ext_q;
    if (state_q == ST_ENTER)
      ext_d = 1'b0;
    else if (state_q == ST_RUN && sel_ext_req_i)
      ext_d = 1'b1;
  end

  assign wdg_d = wdg_q || wdg_start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b0;
      wdg_q <= 1'b0;
    end else begin
      ext_q <= ext_d;
      wdg_q <= wdg_d;
    end
  end

  stop_seq_outreg out_i (
    .clk           (clk),
    .rst           (rst),
    .state_d       (state_d),
    .fpd_d         (fpd_d),
    .lp_d          (lp_d),
    .ext_d         (ext_d),
    .wdg_d         (wdg_d),
    .state_o       (state_o),
    .core_clk_en_o (core_clk_en_o),
    .hsi_en_o      (hsi_en_o),
    .fast_src_en_o (fast_src_en_o),
    .clk_sel_int_o (clk_sel_int_o),
    .flash_pd_o    (flash_pd_o),
    .reg_lp_o      (reg_lp_o),
    .lsi_en_o      (lsi_en_o)
  );

  // R10: return from stop runs on the internal oscillator
  a_r10_wake_internal: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 3'(ST_WAKE) && state_o == 3'(ST_RUN)) |-> (clk_sel_int_o && !fast_src_en_o));
  // R2: without deep enable the block stays in run
  a_r2_no_deep: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'(ST_RUN) && !deep_en_i && !sel_ext_req_i) |=> state_o == 3'(ST_RUN));
endmodule

// File: tb/stop_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module stop_seq_ctrl_tb_top;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 0, deep_en = 0, fpd_en = 0, lp_en = 0, fbusy = 0, bbusy = 0;
  logic wake = 0, osc_rdy = 0, fl_rdy = 0, sel_ext = 0, wdg_start = 0;
  logic [2:0] state_o;
  logic core_clk_en, hsi_en, fast_en, sel_int, flash_pd, reg_lp, lsi_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // reference model state
  int m_st, m_cnt;
  bit m_fpd, m_lp, m_ext, m_wdg;

  always #5 clk = ~clk;

  stop_seq_ctrl #(.FLASH_WAKE_CYCLES(NW)) dut_i (
    .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .deep_en_i(deep_en),
    .flash_pd_en_i(fpd_en), .lp_reg_en_i(lp_en), .flash_busy_i(fbusy),
    .bus_busy_i(bbusy), .wake_i(wake), .osc_ready_i(osc_rdy),
    .flash_ready_i(fl_rdy), .sel_ext_req_i(sel_ext), .wdg_start_i(wdg_start),
    .state_o(state_o), .core_clk_en_o(core_clk_en), .hsi_en_o(hsi_en),
    .fast_src_en_o(fast_en), .clk_sel_int_o(sel_int), .flash_pd_o(flash_pd),
    .reg_lp_o(reg_lp), .lsi_en_o(lsi_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_fpd = 0; m_lp = 0; m_ext = 0; m_wdg = 0;
  endtask

  task automatic model_step();
    int nst;
    bit ok;
    nst = m_st;
    case (m_st)
      0: if (sleep_req && deep_en) nst = 1;
      1: if (wake) nst = 0; else if (!fbusy && !bbusy) nst = 2;
      2: nst = 3;
      3: if (wake) nst = 4;
      default: begin
        ok = osc_rdy && (!m_fpd || (m_cnt == 0 && fl_rdy));
        if (ok) nst = 0;
      end
    endcase
    if (m_st == 1 && nst == 2) begin m_fpd = fpd_en; m_lp = lp_en; end
    if (m_st == 3 && wake) m_cnt = NW - 1;
    else if (m_st == 4 && m_cnt != 0) m_cnt--;
    if (m_st == 2) m_ext = 0;
    else if (m_st == 0 && sel_ext) m_ext = 1;
    if (wdg_start) m_wdg = 1;
    m_st = nst;
  endtask

  task automatic compare_all();
    chk("R3 state", state_o, m_st);
    chk("R4 core_clk_en", core_clk_en, (m_st <= 1));
    chk("R8 hsi_en", hsi_en, (m_st != 3));
    chk("R10 fast_src_en", fast_en, (m_ext && m_st <= 2));
    chk("R10 clk_sel_int", sel_int, !m_ext);
    chk("R5 flash_pd", flash_pd, (m_st == 3 && m_fpd));
    chk("R6 reg_lp", reg_lp, (m_st == 3 && m_lp));
    chk("R11 lsi_en", lsi_en, m_wdg);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic clear_in();
    sleep_req = 0; deep_en = 0; fpd_en = 0; lp_en = 0; fbusy = 0; bbusy = 0;
    wake = 0; osc_rdy = 0; fl_rdy = 0; sel_ext = 0; wdg_start = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset values
    chk("R1 state", state_o, 0);
    chk("R1 core_clk_en", core_clk_en, 1);
    chk("R1 hsi_en", hsi_en, 1);
    chk("R1 fast_src_en", fast_en, 0);
    chk("R1 clk_sel_int", sel_int, 1);
    chk("R1 flash_pd", flash_pd, 0);
    chk("R1 reg_lp", reg_lp, 0);
    chk("R1 lsi_en", lsi_en, 0);

    // R2: sleep without deep enable is ignored
    sleep_req = 1; step(); sleep_req = 0;
    chk("R2 no deep stays run", state_o, 0);
    // R10: switch to external source
    sel_ext = 1; step(); sel_ext = 0;
    chk("R10 ext selected", sel_int, 0);
    chk("R10 fast on", fast_en, 1);
    // R11: start watchdog
    wdg_start = 1; step(); wdg_start = 0;
    chk("R11 lsi on", lsi_en, 1);

    // R2/R3: entry held by flash then bus activity
    sleep_req = 1; deep_en = 1; fbusy = 1; step(); sleep_req = 0;
    chk("R2 wait idle", state_o, 1);
    step(); step();
    chk("R3 held by flash", state_o, 1);
    fbusy = 0; bbusy = 1; step();
    chk("R3 held by bus", state_o, 1);
    bbusy = 0; fpd_en = 1; lp_en = 1; step(); fpd_en = 0; lp_en = 0;
    chk("R3 enter after idle", state_o, 2);
    chk("R4 core gated in enter", core_clk_en, 0);
    chk("R4 fast still on in enter", fast_en, 1);
    step();
    chk("R4 stopped", state_o, 3);
    chk("R4 hsi off", hsi_en, 0);
    chk("R4 fast off", fast_en, 0);
    chk("R5 flash pd", flash_pd, 1);
    chk("R6 reg lp", reg_lp, 1);
    chk("R11 lsi through stop", lsi_en, 1);
    step();
    // R8: wakeup
    wake = 1; osc_rdy = 1; fl_rdy = 1; step(); wake = 0;
    chk("R8 waking", state_o, 4);
    chk("R8 reg normal", reg_lp, 0);
    chk("R8 flash up", flash_pd, 0);
    chk("R8 hsi on", hsi_en, 1);
    n = 0;
    while (state_o == 3'd4 && n < 100) begin n++; step(); end
    chk("R9 flash settle length", n, NW);
    chk("R10 back on internal", sel_int, 1);
    chk("R10 fast off after wake", fast_en, 0);
    chk("R4 core clock back", core_clk_en, 1);

    // R7: wake cancels pending entry
    sleep_req = 1; deep_en = 1; bbusy = 1; step(); sleep_req = 0;
    chk("R7 in wait", state_o, 1);
    bbusy = 0; wake = 1; step(); wake = 0;
    chk("R7 cancelled", state_o, 0);
    chk("R7 clock never gated", core_clk_en, 1);

    // R9: no flash power-down, oscillator gating only
    sleep_req = 1; osc_rdy = 0; step(); sleep_req = 0;
    step(); step();
    chk("R5 no flash pd", flash_pd, 0);
    chk("R6 no reg lp", reg_lp, 0);
    wake = 1; step(); wake = 0;
    step(); step(); step();
    chk("R9 waits for osc", state_o, 4);
    osc_rdy = 1; step();
    chk("R9 quick exit", state_o, 0);

    // constrained random with model comparison
    clear_in();
    for (int i = 0; i < 4000; i++) begin
      sleep_req = ($urandom_range(0, 9) < 2);
      deep_en   = ($urandom_range(0, 3) != 0);
      fpd_en    = $urandom_range(0, 1);
      lp_en     = $urandom_range(0, 1);
      fbusy     = ($urandom_range(0, 3) == 0);
      bbusy     = ($urandom_range(0, 3) == 0);
      wake      = ($urandom_range(0, 15) == 0);
      osc_rdy   = ($urandom_range(0, 3) != 0);
      fl_rdy    = ($urandom_range(0, 2) != 0);
      sel_ext   = ($urandom_range(0, 19) == 0);
      wdg_start = ($urandom_range(0, 999) == 0);
      step();
    end
    clear_in();
    finish_run();
  end
endmodule